// File: doc/BRIEF.md
# Single-Wire Priority Message Transmitter

This block sends one message at a time on an open-drain single-wire bus. A caller presents a payload, a byte count, a priority flag and a one-cycle start strobe. The block then builds the frame: a two-slot sync field, the body bits, a 4-bit CRC over the body, and a final slot in which the bus is released so that the receiving peer can acknowledge. Every slot except the acknowledge slot and the first sync slot of an urgent frame is Manchester coded. The block drives the line only low, through a registered output stage. An external pull-up holds the line high when the block releases it.

There are two formats. An urgent frame carries one byte. Its first sync slot is held low for the whole slot, and the receiver reads that as an interrupt. A bulk frame carries 1 to 7 bytes, preceded by a 3-bit count field. An urgent request that arrives while a bulk frame is on the wire abandons the bulk frame at once and sends the urgent one in its place. The number of system clocks per half slot is set at the start of each frame from a prescale input.

Top module: `swire_prio_tx`

## Requirements
- R1: An urgent frame (`hp_i`=1) is 15 slots long. Slot 0 drives low for both halves. Slot 1 is Manchester 1. Then come the 8 bits of `payload_i[7:0]` MSB first, 4 CRC bits, and one acknowledge slot.
- R2: A bulk frame (`hp_i`=0) has these slots in order. Slot 0 is Manchester 1 and slot 1 is Manchester 0. A 3-bit field follows, holding `count_i` itself, MSB first. Then come bytes `count_i`-1 down to 0 of `payload_i` (byte k is bits 8k+7..8k), each MSB first. Last are 4 CRC bits and one acknowledge slot, for 18 to 66 slots in all.
- R3: The CRC uses the polynomial x^4+x+1 and starts from zero at every frame. It covers the count field and data bits of a bulk frame, and only the data bits of an urgent frame. It is sent MSB first.
- R4: A Manchester bit b takes two halves. `drv_low_o` equals b in the first half and the inverse of b in the second half (a 1 is low then high on the line). The output is constant within each half.
- R5: After reset, and whenever `busy_o` is 0, `drv_low_o` is 0. During the acknowledge slot, `drv_low_o` is 0 in both halves.
- R6: The bus is passed through a two-flop synchronizer and sampled at the end of the first half of the acknowledge slot. A low level gives `ack_ok_o`=1 and a high level gives 0. The value is valid while `done_o` is high and is held until the next accepted start.
- R7: An urgent start that arrives while a bulk frame is in progress abandons that frame. The urgent sync low appears on `drv_low_o` two rising edges after the strobe is sampled. No `done_o` is raised for the abandoned frame.
- R8: A bulk start with `count_i`=0 is ignored. Any start while busy is also ignored, except an urgent start over a bulk frame. An ignored start leaves the running frame and the idle line unchanged.
- R9: Each half slot lasts `prescale_i` clocks, clamped to a minimum of 4. The value is latched when a start is accepted.
- R10: `done_o` is a one-cycle pulse. It rises on the same edge on which `busy_o` falls, right after the last half of the acknowledge slot.
- R11: A start sampled on rising edge E is accepted. `busy_o` and the first half of slot 0 appear after edge E+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| hp_i | input | 1 | 1 = urgent one-byte frame, 0 = bulk frame |
| count_i | input | 3 | Byte count for a bulk frame (1..7) |
| payload_i | input | 56 | Payload, byte k at bits 8k+7..8k |
| prescale_i | input | 8 | Clocks per half slot (minimum 4) |
| bus_i | input | 1 | Level read back from the wire |
| drv_low_o | output | 1 | 1 = pull the wire low, 0 = release |
| busy_o | output | 1 | Frame in progress on the wire |
| done_o | output | 1 | Frame completed, one-cycle pulse |
| ack_ok_o | output | 1 | Acknowledge seen in the last frame |

## Verification
`busy_o` and the first half level are due two rising edges after the strobe. After that, each half-slot level is due every P clocks, where P is the clamped prescale. `done_o` and `ack_ok_o` are due on the edge that ends the final half, with `done_o` low again one clock later. The bench drives inputs and samples outputs on falling edges. A monitor aligns itself on the first falling edge at which `busy_o` is high, then steps exactly P falling edges per half. It compares every sample of each half with a level sequence built from the requirements, with a CRC computed by polynomial division. For preemption, capture starts two falling edges after the urgent strobe.

// File: rtl/swp_pkg.sv
`timescale 1ns/1ps
package swp_pkg;
  typedef enum logic [2:0] {
    SL_IDLE, SL_SYNC0, SL_SYNC1, SL_BODY, SL_CRC, SL_ACK
  } slot_e;

  // drive-low level of a Manchester bit: NRZ xor half-slot phase
  function automatic logic manch_low(input logic nrz, input logic second_half);
    return nrz ^ second_half;
  endfunction
endpackage

// File: rtl/swp_half_timer.sv
`timescale 1ns/1ps
module swp_half_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             half_end_o,
  output logic             phase_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             phase_q;
  logic             wrap;

  assign wrap       = cnt_q == div_i - 1'b1;
  assign half_end_o = run_i && !restart_i && wrap;
  assign phase_o    = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (run_i) begin
      if (wrap) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < div_i);
  a_r9_phase_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_end_o |=> phase_o != $past(phase_o));
endmodule

// File: rtl/swp_crc4.sv
`timescale 1ns/1ps
module swp_crc4 #(
  parameter int unsigned     W    = 4,
  parameter logic [W-1:0]    POLY = 4'b0011
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic feed_i,
  input  logic bit_i,
  input  logic drain_i,
  output logic msb_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb    = bit_i ^ crc_q[W-1];
  assign msb_o = crc_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clear_i) crc_q <= '0;
    else if (feed_i)  crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    else if (drain_i) crc_q <= {crc_q[W-2:0], 1'b0};
  end

  a_r3_drain_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_i && !clear_i) |=> msb_o == $past(crc_q[W-2]));
  a_r3_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !msb_o);
endmodule

// File: rtl/swp_line_drv.sv
`timescale 1ns/1ps
module swp_line_drv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic lvl_low_i,
  input  logic done_i,
  input  logic bus_i,
  output logic drv_low_o,
  output logic busy_o,
  output logic done_o,
  output logic bus_sync_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_low_o <= 1'b0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      sync_q    <= 2'b11;
    end else begin
      drv_low_o <= active_i & lvl_low_i;
      busy_o    <= active_i;
      done_o    <= done_i;
      sync_q    <= {sync_q[0], bus_i};
    end
  end

  assign bus_sync_o = sync_q[1];

  a_r5_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !drv_low_o);
  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/swire_prio_tx.sv
`timescale 1ns/1ps
module swire_prio_tx
  import swp_pkg::*;
#(
  parameter int unsigned       MAX_BYTES = 7,
  parameter int unsigned       DIV_W     = 8,
  parameter int unsigned       MIN_HALF  = 4,
  parameter int unsigned       CRC_W     = 4,
  parameter logic [CRC_W-1:0]  CRC_POLY  = 4'b0011,
  localparam int unsigned      CNT_W     = $clog2(MAX_BYTES + 1),
  localparam int unsigned      PAY_W     = 8 * MAX_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             hp_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [PAY_W-1:0] payload_i,
  input  logic [DIV_W-1:0] prescale_i,
  input  logic             bus_i,
  output logic             drv_low_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ack_ok_o
);
  localparam int unsigned BODY_W = CNT_W + PAY_W;
  localparam int unsigned BC_W   = $clog2(BODY_W + 1);

  slot_e             slot_q;
  logic              hp_q;
  logic [BODY_W-1:0] sh_q;
  logic [BC_W-1:0]   bc_q;
  logic [DIV_W-1:0]  div_q;
  logic              ack_q;
  logic              done_q;

  logic              busy, half_end, phase, slot_end, crc_msb, bus_s, lvl_low;
  logic              cnt_ok, acc_lp, acc_hp, accept;
  logic [PAY_W-1:0]  lp_aligned;
  logic [BODY_W-1:0] load_sh;
  logic [BC_W-1:0]   load_bc;
  logic [DIV_W-1:0]  div_eff;

  assign busy     = slot_q != SL_IDLE;
  assign slot_end = half_end && phase;

  // request acceptance: urgent may preempt a bulk frame
  assign cnt_ok  = (count_i != '0) && (int'(count_i) <= int'(MAX_BYTES));
  assign acc_lp  = start_i && !hp_i && cnt_ok && !busy;
  assign acc_hp  = start_i && hp_i && (!busy || !hp_q);
  assign accept  = acc_lp || acc_hp;

  assign lp_aligned = payload_i << (8 * (int'(MAX_BYTES) - int'(count_i)));
  assign load_sh    = hp_i ? {payload_i[7:0], {(BODY_W-8){1'b0}}} : {count_i, lp_aligned};
  assign load_bc    = hp_i ? BC_W'(7) : BC_W'(int'(CNT_W) + 8 * int'(count_i) - 1);
  assign div_eff    = (prescale_i < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : prescale_i;

  swp_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i, .rst_ni,
    .restart_i (accept),
    .run_i     (busy),
    .div_i     (div_q),
    .half_end_o(half_end),
    .phase_o   (phase)
  );

  swp_crc4 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk_i, .rst_ni,
    .clear_i(accept),
    .feed_i (slot_end && slot_q == SL_BODY && !accept),
    .bit_i  (sh_q[BODY_W-1]),
    .drain_i(slot_end && slot_q == SL_CRC && !accept),
    .msb_o  (crc_msb)
  );

  always_comb begin
    case (slot_q)
      SL_SYNC0: lvl_low = hp_q ? 1'b1 : manch_low(1'b1, phase);
      SL_SYNC1: lvl_low = manch_low(hp_q, phase);
      SL_BODY:  lvl_low = manch_low(sh_q[BODY_W-1], phase);
      SL_CRC:   lvl_low = manch_low(crc_msb, phase);
      default:  lvl_low = 1'b0;
    endcase
  end

  swp_line_drv u_line (
    .clk_i, .rst_ni,
    .active_i  (busy),
    .lvl_low_i (lvl_low),
    .done_i    (done_q),
    .bus_i     (bus_i),
    .drv_low_o (drv_low_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .bus_sync_o(bus_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= SL_IDLE;
      hp_q   <= 1'b0;
      sh_q   <= '0;
      bc_q   <= '0;
      div_q  <= DIV_W'(MIN_HALF);
      ack_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        slot_q <= SL_SYNC0;
        hp_q   <= hp_i;
        sh_q   <= load_sh;
        bc_q   <= load_bc;
        div_q  <= div_eff;
        ack_q  <= 1'b0;
      end else begin
        if (half_end && !phase && slot_q == SL_ACK) ack_q <= ~bus_s;
        if (slot_end) begin
          case (slot_q)
            SL_SYNC0: slot_q <= SL_SYNC1;
            SL_SYNC1: slot_q <= SL_BODY;
            SL_BODY: begin
              sh_q <= {sh_q[BODY_W-2:0], 1'b0};
              if (bc_q == '0) begin
                slot_q <= SL_CRC;
                bc_q   <= BC_W'(CRC_W - 1);
              end else begin
                bc_q <= bc_q - 1'b1;
              end
            end
            SL_CRC: begin
              if (bc_q == '0) slot_q <= SL_ACK;
              else            bc_q   <= bc_q - 1'b1;
            end
            SL_ACK: begin
              slot_q <= SL_IDLE;
              done_q <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign ack_ok_o = ack_q;

  a_r1_hp_sync_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == SL_SYNC0 && hp_q && !accept) |=> drv_low_o);
  a_r5_ack_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == SL_ACK && !accept) |=> !drv_low_o);
  a_r7_preempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && hp_i && busy && !hp_q) |=> (slot_q == SL_SYNC0 && hp_q));
  a_r8_reject_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !hp_i && count_i == '0 && !busy) |=> slot_q == SL_IDLE);
  a_r8_hp_not_restarted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && hp_q && slot_q != SL_ACK) |=> (hp_q && slot_q != SL_IDLE));
  a_r6_ack_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ack_ok_o);
endmodule

// File: tb/swire_prio_tx_tb_top.sv
`timescale 1ns/1ps
module swire_prio_tx_tb_top;
  typedef struct packed {
    logic [139:0] lv;
    logic [7:0]   nh;
    logic [7:0]   p;
    logic         ack;
    logic         hp;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, hp_in = 1'b0;
  logic [2:0]  cnt = '0;
  logic [55:0] payload = '0;
  logic [7:0]  presc = 8'd4;
  logic        bus, drv_low_o, busy_o, done_o, ack_ok_o;
  logic        slave_pull = 1'b0;
  bit          mon_en = 1'b1;
  int          n_chk = 0, n_bad = 0, frames_done = 0, n_done = 0;
  exp_t        q[$];

  always #2.5 clk = ~clk;
  assign bus = ~(drv_low_o | slave_pull);

  swire_prio_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .hp_i(hp_in), .count_i(cnt),
    .payload_i(payload), .prescale_i(presc), .bus_i(bus),
    .drv_low_o(drv_low_o), .busy_o(busy_o), .done_o(done_o), .ack_ok_o(ack_ok_o)
  );

  always @(negedge clk) if (done_o) n_done++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [139:0] act, input logic [139:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected half-slot drive-low levels, CRC by polynomial long division
  function automatic exp_t build(input bit hp, input logic [55:0] pay, input int n,
                                 input bit ack, input int p);
    exp_t e; bit msg [64]; int ml; int k; logic [4:0] rem;
    e = '0; e.ack = ack; e.p = 8'(p); e.hp = hp;
    for (int i = 0; i < 64; i++) msg[i] = 1'b0;
    if (hp) begin
      e.lv[0] = 1; e.lv[1] = 1; e.lv[2] = 1; e.lv[3] = 0;
      ml = 8;
      for (int i = 0; i < 8; i++) msg[i] = pay[7-i];
    end else begin
      e.lv[0] = 1; e.lv[1] = 0; e.lv[2] = 0; e.lv[3] = 1;
      ml = 3 + 8 * n;
      for (int i = 0; i < 3; i++) msg[i] = n[2-i];
      for (int i = 0; i < 8 * n; i++) msg[3+i] = pay[8*n-1-i];
    end
    k = 4;
    rem = '0;
    for (int i = 0; i < ml + 4; i++) begin
      rem = {rem[3:0], (i < ml) ? msg[i] : 1'b0};
      if (rem[4]) rem = rem ^ 5'b10011;
    end
    for (int i = 0; i < ml; i++) begin
      e.lv[k] = msg[i]; e.lv[k+1] = ~msg[i]; k += 2;
    end
    for (int i = 3; i >= 0; i--) begin
      e.lv[k] = rem[i]; e.lv[k+1] = ~rem[i]; k += 2;
    end
    k += 2;  // acknowledge slot released
    e.nh = 8'(k);
    return e;
  endfunction

  // called on the falling edge of the first clock of half 0
  task automatic capture(input exp_t e);
    logic [139:0] got = '0; bit unstable = 0; int h; int p = int'(e.p); int nh = int'(e.nh);
    string tg = e.hp ? "R1,R3" : "R2,R3";
    for (h = 0; h < nh; h++) begin
      if (!busy_o) break;
      got[h] = drv_low_o;
      slave_pull = e.ack && (h >= nh - 2);
      for (int c = 0; c < p; c++) begin
        if (drv_low_o !== got[h]) unstable = 1;
        @(negedge clk);
      end
    end
    slave_pull = 1'b0;
    chk(got == e.lv, tg, "half-slot levels", got, e.lv);
    chk(!unstable, "R4", "level constant within half", 140'(unstable), 0);
    chk(h == nh && busy_o == 0 && done_o == 1, "R9/R10", "frame length and done",
        140'(h), 140'(nh));
    chk(ack_ok_o == e.ack, "R6", "ack_ok", 140'(ack_ok_o), 140'(e.ack));
    @(negedge clk);
    chk(done_o == 0, "R10", "done single pulse", 140'(done_o), 0);
  endtask

  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (mon_en && busy_o && q.size() > 0) begin
        e = q.pop_front();
        capture(e);
        frames_done++;
      end
    end
  end

  task automatic send(input bit hp, input logic [55:0] pay, input int n, input int pr,
                      input bit ack, input int poke);
    int p = (pr < 4) ? 4 : pr;
    int tgt;
    exp_t e = build(hp, pay, n, ack, p);
    @(negedge clk);
    start = 1; hp_in = hp; cnt = 3'(n); payload = pay; presc = 8'(pr);
    q.push_back(e);
    tgt = frames_done + 1;
    @(negedge clk);
    start = 0;
    chk(busy_o == 0, "R11", "busy one edge after accept", 140'(busy_o), 0);
    @(negedge clk);
    chk(busy_o == 1 && drv_low_o == e.lv[0], "R11", "busy and first half after two edges",
        140'({busy_o, drv_low_o}), 140'({1'b1, e.lv[0]}));
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      start = 1; hp_in = hp; cnt = 3'd5; payload = ~pay;  // R8: must be ignored
      @(negedge clk);
      start = 0;
    end
    wait (frames_done == tgt);
    if (poke > 0) begin
      repeat (8) @(negedge clk);
      chk(busy_o == 0 && drv_low_o == 0, "R8", "start while busy ignored",
          140'({busy_o, drv_low_o}), 0);
    end
  endtask

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && drv_low_o == 0 && done_o == 0 && ack_ok_o == 0, "R5",
        "reset state", 140'({busy_o, drv_low_o, done_o, ack_ok_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy_o == 0 && drv_low_o == 0, "R5", "idle released", 140'({busy_o, drv_low_o}), 0);

    send(1, 56'hA5, 1, 4, 1, 0);                   // R1 urgent, acknowledged
    send(1, 56'h00, 1, 4, 0, 0);                   // R6 missing acknowledge
    send(0, 56'h3C, 1, 4, 1, 0);                   // R2 shortest bulk frame
    send(0, 56'h0123456789ABCD, 7, 4, 1, 0);       // R2 longest bulk frame
    send(0, 56'h00_0000_00F00D, 3, 6, 0, 0);       // R9 prescale 6
    send(1, 56'h81, 1, 2, 1, 0);                   // R9 prescale clamped to 4
    send(0, 56'h0000_0000_00BEEF, 2, 4, 1, 20);    // R8 bulk start while busy
    send(1, 56'h7E, 1, 4, 1, 20);                  // R8 urgent start over urgent

    // R8: zero count rejected
    @(negedge clk);
    start = 1; hp_in = 0; cnt = 3'd0; payload = 56'hFF;
    @(negedge clk);
    start = 0;
    repeat (6) @(negedge clk);
    chk(busy_o == 0 && drv_low_o == 0, "R8", "zero count ignored", 140'({busy_o, drv_low_o}), 0);

    // R7: urgent preempts a bulk frame
    mon_en = 0;
    @(negedge clk);
    start = 1; hp_in = 0; cnt = 3'd7; payload = 56'hFFFF_FFFF_FFFF_FF; presc = 8'd4;
    @(negedge clk);
    start = 0;
    repeat (40) @(negedge clk);
    d0 = n_done;
    start = 1; hp_in = 1; payload = 56'h5A;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    chk(n_done == d0 && busy_o == 1, "R7", "no done for abandoned frame",
        140'(n_done - d0), 0);
    capture(build(1, 56'h5A, 1, 1, 4));
    chk(n_done == d0 + 1, "R7", "one done after preemption", 140'(n_done - d0), 1);
    mon_en = 1;

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule